// File: doc/BRIEF.md
# Bidirectional Systolic Convolution Array

This block computes a finite convolution with a straight chain of `TAPS` identical cells. Each cell holds one fixed coefficient. Samples enter at the left end and step one cell to the right per clock. Partial sums are launched as zero at the right end and step one cell to the left per clock. When a sample and a partial sum sit at the same cell in the same cycle, the cell adds the sample times its coefficient into the sum. A sum that reaches the left end has passed every cell and leaves as one output term y_i = w_1·x_i + w_2·x_(i+1) + … + w_k·x_(i+k-1).

Samples and partial sums close on each other at two cells per clock. They therefore have to be spaced two clocks apart, or a sum would skip every second sample. The block runs a free-running two-phase schedule and takes a sample only in an open slot. Partial-sum slots are launched on the phase that makes every sample meet one live sum in every cell, so about half the cells are busy in any cycle. Each moving token carries a valid bit, and each sum carries a count of the products it has collected. Only a sum that collected all `TAPS` products is presented at the output. A stream of n back-to-back samples therefore yields exactly n+1-TAPS results.

Coefficients are written one at a time through the load port before a stream starts and stay unchanged while the stream runs.

Top module: `sconv_array`

## Requirements
- R1: A cycle with `wt_load` high stores `wt_data` (signed) as coefficient w_(j+1), where j = `wt_idx` (0 to TAPS-1). The new value is used from the next cycle on.
- R2: `slot_open` is 1 in the first cycle with `rst` low and inverts on every later cycle. A sample is taken in a cycle where both `in_valid` and `slot_open` are 1.
- R3: A cycle with `in_valid` high and `slot_open` low has no effect on any result.
- R4: Number the samples taken x_0, x_1, … . Result i equals the sum over j = 0..TAPS-1 of w_(j+1)·x_(i+j), with signed samples and coefficients and a signed result on `res_data`.
- R5: Result i shows on `res_valid`/`res_data` in the cycle that directly follows the cycle in which x_(i+TAPS-1) was taken.
- R6: A run of n samples taken in consecutive open slots produces exactly n+1-TAPS results when n ≥ TAPS, and none when n < TAPS.
- R7: An open slot with no sample breaks the stream. No result is produced for a window of TAPS samples that spans that slot, and windows wholly on either side of it are still produced correctly.
- R8: The result width holds the sum of TAPS full-scale products without overflow. The extreme case is every sample and every coefficient at the most negative value.
- R9: While `rst` is high, `res_valid` is 0. Reset clears all coefficients to zero and drops every sample and partial sum in flight, so samples taken before reset never contribute to a later result.
- R10: `res_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wt_load | input | 1 | Write one coefficient this cycle |
| wt_idx | input | IDX_W | Coefficient number j (0-based, selects w_(j+1)) |
| wt_data | input | WGT_W | Signed coefficient value |
| in_valid | input | 1 | A sample is offered this cycle |
| in_data | input | DATA_W | Signed sample value |
| slot_open | output | 1 | A sample offered this cycle is taken |
| res_valid | output | 1 | `res_data` holds a complete result |
| res_data | output | ACC_W | Signed convolution result |

## Verification
An impulse in a zero stream returns the coefficients in reverse order, which shows that each coefficient sits at its own tap and pairs with the right sample. A rising ramp and a sign-alternating sequence give results in which a sample paired with the wrong tap, or met twice, changes the sum. Full-scale negative data against full-scale negative weights tests the width of the accumulator. Junk values offered in closed slots, a skipped open slot, a stream shorter than the tap count, and a reset in the middle of a stream check which windows are allowed to complete.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

    // Block configuration and derived sizes
    localparam int TAPS   = 4;
    localparam int DATA_W = 8;
    localparam int WGT_W  = 8;
    localparam int ACC_W  = DATA_W + WGT_W + $clog2(TAPS);
    localparam int CNT_W  = $clog2(TAPS + 1);
    localparam int IDX_W  = (TAPS > 1) ? $clog2(TAPS) : 1;

    // Partial-sum slots are launched on the phase that lines them up with samples
    localparam logic SLOT_SKEW = ((TAPS - 1) % 2) == 1;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [WGT_W-1:0]  weight_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic    valid;
        sample_t value;
    } sample_tok_t;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] hits;
        acc_t             sum;
    } psum_tok_t;

    function automatic acc_t mac(acc_t base, sample_t s, weight_t w);
        acc_t se;
        acc_t we;
        se = acc_t'(s);
        we = acc_t'(w);
        return base + se * we;
    endfunction

endpackage

// File: rtl/sconv_weights.sv
module sconv_weights
    import sconv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] idx,
    input  weight_t          data,
    output weight_t          coef [TAPS]
);

    weight_t coef_q [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TAPS; j++) coef_q[j] <= '0;
        end else if (load) begin
            for (int j = 0; j < TAPS; j++) begin
                if (idx == IDX_W'(j)) coef_q[j] <= data;
            end
        end
    end

    assign coef = coef_q;

endmodule

// File: rtl/sconv_inject.sv
module sconv_inject
    import sconv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  sample_t     in_data,
    output logic        slot_open,
    output sample_tok_t x_tok,
    output psum_tok_t   y_tok
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b1;
        else     open_q <= ~open_q;
    end

    assign slot_open = open_q;

    always_comb begin
        x_tok.valid = in_valid & open_q;
        x_tok.value = in_data;
        y_tok.valid = open_q ^ SLOT_SKEW;
        y_tok.hits  = '0;
        y_tok.sum   = '0;
    end

    AST_SLOT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (slot_open != $past(slot_open))); // R2

endmodule

// File: rtl/sconv_cell.sv
module sconv_cell
    import sconv_pkg::*;
#(
    parameter int POS = 0
)(
    input  logic        clk,
    input  logic        rst,
    input  weight_t     coef,
    input  sample_tok_t x_in,
    input  psum_tok_t   y_in,
    output sample_tok_t x_out,
    output psum_tok_t   y_out
);

    sample_tok_t x_q;
    psum_tok_t   y_q;
    psum_tok_t   y_n;

    always_comb begin
        y_n = y_in;
        if (x_in.valid && y_in.valid) begin
            y_n.sum  = mac(y_in.sum, x_in.value, coef);
            y_n.hits = y_in.hits + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_in;
            y_q <= y_n;
        end
    end

    assign x_out = x_q;
    assign y_out = y_q;

    // A sum leaving this cell has crossed only TAPS-POS cells
    AST_HIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        y_q.hits <= CNT_W'(TAPS - POS)); // R6

    AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (rst)
        y_q.valid |=> !y_q.valid); // R2

endmodule

// File: rtl/sconv_array.sv
module sconv_array
    import sconv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_load,
    input  logic [IDX_W-1:0]  wt_idx,
    input  logic [WGT_W-1:0]  wt_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              slot_open,
    output logic              res_valid,
    output logic [ACC_W-1:0]  res_data
);

    weight_t     coef [TAPS];
    sample_tok_t xbus [TAPS+1];
    psum_tok_t   ybus [TAPS+1];

    sconv_weights u_wts (
        .clk  (clk),
        .rst  (rst),
        .load (wt_load),
        .idx  (wt_idx),
        .data (weight_t'(wt_data)),
        .coef (coef)
    );

    sconv_inject u_inj (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (sample_t'(in_data)),
        .slot_open (slot_open),
        .x_tok     (xbus[0]),
        .y_tok     (ybus[TAPS])
    );

    // Cell c holds w_(TAPS-c): the leftmost cell meets the newest sample of a window
    for (genvar c = 0; c < TAPS; c++) begin : g_cell
        sconv_cell #(.POS(c)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .coef  (coef[TAPS-1-c]),
            .x_in  (xbus[c]),
            .y_in  (ybus[c+1]),
            .x_out (xbus[c+1]),
            .y_out (ybus[c])
        );
    end

    assign res_valid = ybus[0].valid && (ybus[0].hits == CNT_W'(TAPS));
    assign res_data  = ybus[0].sum;

    AST_NO_STALE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !slot_open) |=> !xbus[1].valid); // R3

    AST_RESULT_SPACING: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !res_valid); // R9

endmodule

// File: tb/sim_sconv_array.sv
module sim_sconv_array;
    import sconv_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wt_load = 1'b0;
    logic [IDX_W-1:0]  wt_idx = '0;
    logic [WGT_W-1:0]  wt_data = '0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              slot_open;
    logic              res_valid;
    logic [ACC_W-1:0]  res_data;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 0;

    longint wref [TAPS];
    longint din [64];
    longint got_v [$];
    int     got_c [$];
    int     acc_c [$];
    logic   prev_rv = 1'b0;

    sconv_array u0 (
        .clk(clk), .rst(rst), .wt_load(wt_load), .wt_idx(wt_idx), .wt_data(wt_data),
        .in_valid(in_valid), .in_data(in_data), .slot_open(slot_open),
        .res_valid(res_valid), .res_data(res_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output collector; also watches result spacing
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            longint v;
            v = $signed(res_data);
            got_v.push_back(v);
            got_c.push_back(cyc);
            if (prev_rv) check(1'b0, "R10 back-to-back results", 1, 0);
        end
        prev_rv = rst ? 1'b0 : res_valid;
    end

    task automatic do_reset(input int n);
        rst = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(res_valid == 1'b0, "R9 res_valid during reset", res_valid, 0);
        end
        for (int j = 0; j < TAPS; j++) wref[j] = 0;
        rst = 1'b0;
    endtask

    task automatic load_weights(input longint w0, input longint w1, input longint w2, input longint w3);
        longint wl [4];
        wl = '{w0, w1, w2, w3};
        for (int j = 0; j < TAPS; j++) begin
            wt_load = 1'b1;
            wt_idx  = IDX_W'(j);
            wt_data = WGT_W'(wl[j % 4]);
            @(negedge clk);
            wref[j] = wl[j % 4];
        end
        wt_load = 1'b0;
    endtask

    // Streams din[0..n-1]; gap_at >= 0 leaves one open slot empty before that sample
    task automatic run_stream(input string name, input int n, input int gap_at, input bit junk);
        int pos [64];
        longint exp_v [$];
        int exp_c [$];
        got_v.delete(); got_c.delete(); acc_c.delete();
        for (int m = 0; m < n; m++) begin
            if (m == gap_at) begin
                while (!slot_open) @(negedge clk);
                in_valid = 1'b0;
                @(negedge clk);
            end
            while (!slot_open) begin
                if (junk) begin
                    in_valid = 1'b1;
                    in_data  = DATA_W'(8'h5A ^ m);
                end
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = DATA_W'(din[m]);
            acc_c.push_back(cyc);
            pos[m] = (gap_at >= 0 && m >= gap_at) ? m + 1 : m;
            @(negedge clk);
            in_valid = 1'b0;
        end
        in_valid = 1'b0;
        repeat (2*TAPS + 4) @(negedge clk);
        for (int i = 0; i + TAPS - 1 < n; i++) begin
            if (pos[i+TAPS-1] - pos[i] == TAPS - 1) begin
                longint s;
                s = 0;
                for (int j = 0; j < TAPS; j++) s += wref[j] * din[i+j];
                exp_v.push_back(s);
                exp_c.push_back(acc_c[i+TAPS-1] + 1);
            end
        end
        check(got_v.size() == exp_v.size(),
              {name, (gap_at >= 0) ? " R7 result count" : " R6 result count"},
              got_v.size(), exp_v.size());
        for (int i = 0; i < exp_v.size() && i < got_v.size(); i++) begin
            check(got_v[i] == exp_v[i], {name, " R4 value"}, got_v[i], exp_v[i]);
            check(got_c[i] == exp_c[i], {name, " R5 timing"}, got_c[i], exp_c[i]);
        end
    endtask

    task automatic t_reset;
        do_reset(3);
        check(slot_open == 1'b1, "R2 slot open after reset", slot_open, 1);
        check(res_valid == 1'b0, "R9 idle after reset", res_valid, 0);
    endtask

    task automatic t_toggle;
        logic prev;
        prev = slot_open;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(slot_open == ~prev, "R2 slot toggles", slot_open, ~prev);
            prev = slot_open;
        end
    endtask

    task automatic t_zero_weights;
        for (int m = 0; m < 6; m++) din[m] = m + 3;
        run_stream("zero weights R9", 6, -1, 1'b0);
    endtask

    task automatic t_impulse;
        load_weights(3, -2, 5, 7);   // R1
        for (int m = 0; m < 7; m++) din[m] = (m == 3) ? 1 : 0;
        run_stream("impulse R1", 7, -1, 1'b0);
    endtask

    task automatic t_ramp;
        for (int m = 0; m < 10; m++) din[m] = m + 1;
        run_stream("ramp", 10, -1, 1'b0);
    endtask

    task automatic t_alternate;
        load_weights(-9, 4, 11, -1);
        for (int m = 0; m < 12; m++) din[m] = (m % 2 == 0) ? (m * 7 - 40) : (50 - m * 3);
        run_stream("alternating", 12, -1, 1'b0);
    endtask

    task automatic t_extremes;
        load_weights(-128, -128, -128, -128);
        for (int m = 0; m < 6; m++) din[m] = -128;
        run_stream("extremes R8", 6, -1, 1'b0);
        load_weights(127, -128, 127, -128);
        for (int m = 0; m < 6; m++) din[m] = (m % 2 == 0) ? 127 : -128;
        run_stream("mixed extremes R8", 6, -1, 1'b0);
    endtask

    task automatic t_junk;
        load_weights(2, 3, -4, 6);
        for (int m = 0; m < 8; m++) din[m] = 10 - 3 * m;
        run_stream("closed-slot junk R3", 8, -1, 1'b1);
    endtask

    task automatic t_gap;
        for (int m = 0; m < 10; m++) din[m] = m * 5 - 20;
        run_stream("skipped slot", 10, 5, 1'b0);
    endtask

    task automatic t_short;
        for (int m = 0; m < TAPS - 1; m++) din[m] = 9;
        run_stream("short stream", TAPS - 1, -1, 1'b0);
    endtask

    task automatic t_mid_reset;
        in_valid = 1'b1;
        in_data  = DATA_W'(100);
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        do_reset(2);
        load_weights(1, 2, 3, 4);
        for (int m = 0; m < TAPS; m++) din[m] = m + 1;
        run_stream("after mid-stream reset R9", TAPS, -1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < TAPS; j++) wref[j] = 0;
        @(negedge clk);
        t_reset;
        t_toggle;
        t_zero_weights;
        t_impulse;
        t_ramp;
        t_alternate;
        t_extremes;
        t_junk;
        t_gap;
        t_short;
        t_mid_reset;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule